// File: doc/BRIEF.md
# Endpoint DMA Request Generator

This block raises one DMA request line on behalf of a single data endpoint chosen from six. A byte-wide control register, written through a simple write strobe, enables DMA, picks the serviced endpoint and selects the request policy. The block watches per-endpoint status pulses: transmit-done for the transmit endpoints and receive-last for the receive endpoints, plus a FIFO warning flag for every endpoint.

In completion mode the request is raised when the selected endpoint finishes a transfer. For a transmit endpoint that is its transmit-done pulse, which signals that its FIFO may be refilled. For a receive endpoint it is its receive-last pulse. In warning mode the request follows the selected endpoint's FIFO warning flag. The request stays up until the DMA acknowledge arrives. In warning mode it also drops once the warning clears. Three further control bits, for receive-toggle ignore, data toggle and automatic DMA, are stored and read back but do not affect the request.

Top module: `dma_req_gen`

## Requirements
- R1: After reset the control register reads 0x00 and `dma_req` is low.
- R2: A write with `wr_en` high stores `wr_data` in the control register, and the stored value shows on `ctrl_q` after the next clock edge. Bits 6, 5 and 4 of the register have no effect on `dma_req`.
- R3: Control bit 3 is the mode bit. When it is 0, the request is raised in the cycle after a completion pulse of the selected endpoint. Bits 2:0 are the select field: value s selects endpoint s+1. Odd endpoints 1, 3 and 5 use `tx_done[0]`, `tx_done[1]` and `tx_done[2]`. Even endpoints 2, 4 and 6 use `rx_last[0]`, `rx_last[1]` and `rx_last[2]`.
- R4: Status pulses that belong to a different endpoint, or that do not match the current mode, never raise `dma_req`.
- R5: When bit 3 is 1, the request is raised in the cycle after `fifo_warn[s]` of the selected endpoint is seen high. It falls in the cycle after that warning is seen low. Completion pulses are ignored in this mode.
- R6: Once raised, `dma_req` stays high until `dma_ack` is sampled high, and it is low in the following cycle.
- R7: Select values 6 and 7 never raise `dma_req`.
- R8: Bit 7 is the DMA enable. While it is 0, `dma_req` stays low.
- R9: A write that changes the select field, or that clears bit 7, drops a pending request in the next cycle, and the request does not come back when DMA is re-enabled. A write that keeps the select field and keeps bit 7 set leaves the request in place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 8 | Control register write value |
| ctrl_q | output | 8 | Control register contents |
| tx_done | input | 3 | Transmit-done pulses for endpoints 1, 3, 5 |
| rx_last | input | 3 | Receive-last pulses for endpoints 2, 4, 6 |
| fifo_warn | input | 6 | FIFO warning flags, bit s for endpoint s+1 |
| dma_ack | input | 1 | DMA acknowledge |
| dma_req | output | 1 | DMA request |

## Verification
The hardest case to reach from the ports is a pending request that meets a control write. Whether that write keeps the request or drops it depends on whether the select field changes and on whether the enable stays set. The bench first builds a pending request with a completion pulse. It then issues a same-value write, a select change and an enable clear, each on a fresh pending request. After each write it re-enables DMA to show that the dropped request stays gone. A sweep covers every select value, both modes and every status line one at a time, and the expected request is computed from the endpoint arithmetic.

// File: rtl/dma_req_gen.sv
`timescale 1ns/1ps
module dma_req_gen #(
  parameter int N_EP = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [7:0]        wr_data,
  output logic [7:0]        ctrl_q,
  input  logic [N_EP/2-1:0] tx_done,
  input  logic [N_EP/2-1:0] rx_last,
  input  logic [N_EP-1:0]   fifo_warn,
  input  logic              dma_ack,
  output logic              dma_req
);
  localparam int HALF = N_EP / 2;

  logic [7:0]      ctrl;
  logic            pending;
  logic [N_EP-1:0] done_vec;

  wire       den  = ctrl[7];
  wire       mode = ctrl[3];
  wire [2:0] sel  = ctrl[2:0];
  wire       sel_ok = int'(sel) < N_EP;

  for (genvar i = 0; i < HALF; i++) begin : g_pair
    assign done_vec[2*i]   = tx_done[i];
    assign done_vec[2*i+1] = rx_last[i];
  end

  wire done_sel = sel_ok && done_vec[sel];
  wire warn_sel = sel_ok && fifo_warn[sel];
  wire trigger  = den && sel_ok && (mode ? warn_sel : done_sel);
  wire wr_drop  = wr_en && (wr_data[2:0] != sel || !wr_data[7]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl <= 8'h00;
    else if (wr_en) ctrl <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                pending <= 1'b0;
    else if (wr_drop)          pending <= 1'b0;
    else if (dma_ack)          pending <= 1'b0;
    else if (mode && !warn_sel) pending <= 1'b0;
    else if (trigger)          pending <= 1'b1;
  end

  assign dma_req = pending && den;
  assign ctrl_q  = ctrl;

  // R8
  req_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |-> ctrl_q[7]);

  // R6
  ack_clears_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dma_ack |=> !dma_req);

  // R7
  reserved_sel_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[2:0] >= 3'd6) |-> !dma_req);

  // R5
  warn_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[3] && !warn_sel) |=> !dma_req);

  // R9
  write_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_data[2:0] != ctrl_q[2:0] || !wr_data[7])) |=> !dma_req);

  // R3
  rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dma_req) |-> $past(ctrl_q[7]) && $past(ctrl_q[2:0] < 3'd6));
endmodule

// File: tb/dma_req_gen_test.sv
`timescale 1ns/1ps
module dma_req_gen_test;
  logic clk = 0, rst_n = 0, wr_en = 0, dma_ack = 0;
  logic [7:0] wr_data = 0;
  logic [2:0] tx_done = 0, rx_last = 0;
  logic [5:0] fifo_warn = 0;
  logic [7:0] ctrl_q;
  logic dma_req;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  dma_req_gen uut (.clk, .rst_n, .wr_en, .wr_data, .ctrl_q, .tx_done,
                   .rx_last, .fifo_warn, .dma_ack, .dma_req);

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] v);
    @(negedge clk); wr_en = 1; wr_data = v;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic edge_sample;
    @(posedge clk); #1;
  endtask

  task automatic set_line(int k, logic v);
    if (k < 3) tx_done[k] = v;
    else if (k < 6) rx_last[k-3] = v;
    else fifo_warn[k-6] = v;
  endtask

  task automatic ack_clear;
    @(negedge clk); dma_ack = 1;
    edge_sample();
    @(negedge clk); dma_ack = 0;
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #22 rst_n = 1;
    #1;
    chk("R1 ctrl", ctrl_q, 8'h00);
    chk("R1 req", {7'b0, dma_req}, 8'h00);

    wr(8'hA5); chk("R2 readback", ctrl_q, 8'hA5);
    wr(8'h7E); chk("R2 readback", ctrl_q, 8'h7E);
    ack_clear();

    for (int en = 0; en < 2; en++)
      for (int mode = 0; mode < 2; mode++)
        for (int sel = 0; sel < 8; sel++)
          for (int k = 0; k < 12; k++) begin
            int idx;
            logic exp;
            logic [7:0] v;
            idx = (k < 3) ? 2*k : (k < 6) ? 2*(k-3)+1 : k-6;
            exp = en == 1 && sel < 6 &&
                  (mode == 1 ? (k >= 6 && idx == sel) : (k < 6 && idx == sel));
            v = 8'(en << 7) | 8'(((sel + k) & 7) << 4) | 8'(mode << 3) | 8'(sel);
            wr(v);
            @(negedge clk); set_line(k, 1'b1);
            edge_sample();
            if (en == 0) chk("R8 gated", {7'b0, dma_req}, 8'(exp));
            else if (sel >= 6) chk("R7 reserved", {7'b0, dma_req}, 8'(exp));
            else if (!exp) chk("R4 ignored", {7'b0, dma_req}, 8'(exp));
            else if (mode == 1) chk("R5 warn", {7'b0, dma_req}, 8'(exp));
            else chk("R3 done", {7'b0, dma_req}, 8'(exp));
            @(negedge clk); set_line(k, 1'b0); dma_ack = 1;
            edge_sample();
            chk("R6 ack", {7'b0, dma_req}, 8'h00);
            @(negedge clk); dma_ack = 0;
          end

    wr(8'h80);
    @(negedge clk); tx_done[0] = 1;
    @(negedge clk); tx_done[0] = 0;
    for (int i = 0; i < 5; i++) begin
      edge_sample(); chk("R6 hold", {7'b0, dma_req}, 8'h01);
    end
    ack_clear(); chk("R6 drop", {7'b0, dma_req}, 8'h00);

    wr(8'h8D);
    @(negedge clk); fifo_warn[5] = 1;
    for (int i = 0; i < 3; i++) begin
      edge_sample(); chk("R5 follow", {7'b0, dma_req}, 8'h01);
    end
    @(negedge clk); fifo_warn[5] = 0;
    edge_sample(); chk("R5 release", {7'b0, dma_req}, 8'h00);

    wr(8'h81);
    @(negedge clk); rx_last[0] = 1;
    @(negedge clk); rx_last[0] = 0;
    #1 chk("R9 pending", {7'b0, dma_req}, 8'h01);
    wr(8'hF1); chk("R9 same select keeps", {7'b0, dma_req}, 8'h01);
    wr(8'h82); chk("R9 select change drops", {7'b0, dma_req}, 8'h00);
    wr(8'h81); chk("R9 no revival", {7'b0, dma_req}, 8'h00);
    @(negedge clk); rx_last[0] = 1;
    @(negedge clk); rx_last[0] = 0;
    wr(8'h01); chk("R9 enable clear drops", {7'b0, dma_req}, 8'h00);
    wr(8'h81); chk("R9 re-enable stays low", {7'b0, dma_req}, 8'h00);

    @(negedge clk); tx_done[1] = 1;
    @(negedge clk); tx_done[1] = 0;
    wr(8'h82);
    @(negedge clk); tx_done[1] = 1;
    @(negedge clk); tx_done[1] = 0;
    #1 chk("R3 endpoint 3 pending", {7'b0, dma_req}, 8'h01);
    rst_n = 0; #1;
    chk("R1 reset ctrl", ctrl_q, 8'h00);
    chk("R1 reset req", {7'b0, dma_req}, 8'h00);
    @(negedge clk); rst_n = 1;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule